// File: doc/BRIEF.md
# Return address prediction stack

This block is a small last-in-first-out store that lets an instruction fetch unit guess where a function return will go before the real target is known. The front end raises a call strobe together with the address that follows the call, and the block records that address as the new top. When the front end raises a return strobe, the block offers the top address as the predicted target in that same cycle and removes it from the stack.

A push-enable control stops only the recording of new call addresses. Returns keep popping and predicting from whatever entries were already held, which means those entries can be stale. A separate flush strobe discards every held entry, so that no prediction can come from outdated addresses. When the stack is full, a further call overwrites the oldest entry, so the most recent call depth is always kept.

Top module: `rtn_pred_stack`

## Requirements
- R1: With push enable high, a call strobe records its address as the new top entry, so that the next return predicts that address.
- R2: A return strobe on a non-empty stack raises pred_valid_o in the same cycle with pred_addr_o equal to the top entry, and removes that entry. Successive returns give addresses in last-in-first-out order.
- R3: With push enable low, a call strobe leaves the stack unchanged. The next return predicts the entry that was on top before that call.
- R4: With push enable low, returns still pop and predict from the older entries in order until the stack is empty.
- R5: A flush strobe empties the stack, so every return after it predicts nothing until a new call is recorded.
- R6: The stack holds DEPTH entries. A call on a full stack drops the oldest entry and keeps the newest, so DEPTH returns then give the newest DEPTH addresses and the next return predicts nothing.
- R7: A return on an empty stack gives pred_valid_o low and leaves the stack empty. A single later call is then followed by exactly one valid prediction.
- R8: When call (enabled) and return arrive in the same cycle, the pop is done first and the push second. The prediction in that cycle is the old top, the new address becomes the top, and the depth is unchanged on a non-empty stack.
- R9: A flush in the same cycle as a call and/or a return takes priority. No prediction is made in that cycle, the call address is not recorded, and the stack is empty afterwards.
- R10: Reset, asynchronous and active low, empties the stack. A return during or just after reset predicts nothing.
- R11: Whenever pred_valid_o is low, pred_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_en_i | input | 1 | Allows calls to record addresses when high |
| call_i | input | 1 | Call detected this cycle |
| call_ret_addr_i | input | ADDR_W | Return address belonging to the call |
| ret_i | input | 1 | Return detected this cycle |
| flush_i | input | 1 | Discard all held entries |
| pred_addr_o | output | ADDR_W | Predicted return target, zero when not valid |
| pred_valid_o | output | 1 | Prediction is valid this cycle |

## Verification
The bench builds two copies side by side with 8-bit addresses: one with DEPTH 4, which takes the power-of-two pointer wrap, and one with DEPTH 3, which takes the compare-based wrap. Both copies see the same stimulus. These shallow stacks reach full, overwrite-on-full, empty-pop and wrap-around states within a few cycles. This lets a long pseudo-random sweep of every combination of call, return, enable and flush visit all depth levels many times. A queue model of each depth in the bench predicts every output in every cycle.

// File: rtl/rtn_pred_pkg.sv
package rtn_pred_pkg;

   // Stack operation selected in a cycle: {push, pop}
   typedef enum logic [1:0] {
      OP_HOLD = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_SWAP = 2'b11
   } stk_op_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rtn_pred_ptr.sv
module rtn_pred_ptr
   import rtn_pred_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = idx_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_en_i,
   input  logic             call_i,
   input  logic             ret_i,
   input  logic             flush_i,
   output logic [PTR_W-1:0] top_idx_o,
   output logic [CNT_W-1:0] count_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] IDX_LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] top_q, top_d, top_dn, mid_idx, wr_idx;
   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_mid;
   logic             has_entry, do_pop, do_push;
   stk_op_e          op;

   assign has_entry = (cnt_q != '0);
   assign do_pop    = ret_i & has_entry;
   assign do_push   = call_i & push_en_i;
   assign op        = stk_op_e'({do_push, do_pop});

   // Pointer wrap: a power-of-two depth wraps for free, others compare
   if (is_pow2(DEPTH)) begin : g_wrap_pow2
      assign top_dn = top_q - PTR_W'(1);
      assign wr_idx = mid_idx + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign top_dn = (top_q == '0) ? IDX_LAST : top_q - PTR_W'(1);
      assign wr_idx = (mid_idx == IDX_LAST) ? '0 : mid_idx + PTR_W'(1);
   end

   // Pop stage: applied before any push of the same cycle
   always_comb begin
      mid_idx = top_q;
      cnt_mid = cnt_q;
      if ((op == OP_POP) || (op == OP_SWAP)) begin
         mid_idx = top_dn;
         cnt_mid = cnt_q - CNT_W'(1);
      end
   end

   // Push stage and flush override
   always_comb begin
      top_d = mid_idx;
      cnt_d = cnt_mid;
      case (op)
         OP_PUSH, OP_SWAP: begin
            top_d = wr_idx;
            cnt_d = (cnt_mid == CNT_FULL) ? CNT_FULL : cnt_mid + CNT_W'(1);
         end
         default: ;
      endcase
      if (flush_i) begin
         top_d = '0;
         cnt_d = '0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         top_q <= '0;
         cnt_q <= '0;
      end else begin
         top_q <= top_d;
         cnt_q <= cnt_d;
      end
   end

   assign top_idx_o = top_q;
   assign count_o   = cnt_q;
   assign wr_en_o   = do_push & ~flush_i;
   assign wr_idx_o  = wr_idx;

   // R6: depth never exceeds capacity
   p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_FULL);

   // R5: flush leaves nothing behind
   p_flush_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (cnt_q == '0));

   // R3: a disabled call alone does not move the stack
   p_call_off_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (call_i && !push_en_i && !ret_i && !flush_i) |=> ($stable(cnt_q) && $stable(top_q)));

   // R4: a return without push removes exactly one entry
   p_pop_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !(call_i && push_en_i) && !flush_i && (cnt_q != '0))
      |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

   // R8: simultaneous call and return keeps the depth
   p_swap_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && call_i && push_en_i && !flush_i && (cnt_q != '0)) |=> $stable(cnt_q));

   // R7: popping empty stays empty
   p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && !(call_i && push_en_i) && !flush_i && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/rtn_pred_store.sv
module rtn_pred_store
   import rtn_pred_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned PTR_W = idx_width(DEPTH)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);

   logic [ADDR_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (wr_en_i) begin
         slot_q[wr_idx_i] <= wr_data_i;
      end
   end

   assign rd_data_o = slot_q[rd_idx_i];

   // R1: a written address is held in the slot it was sent to
   p_write_lands_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (slot_q[$past(wr_idx_i)] == $past(wr_data_i)));

endmodule

// File: rtl/rtn_pred_stack.sv
module rtn_pred_stack
   import rtn_pred_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_en_i,
   input  logic              call_i,
   input  logic [ADDR_W-1:0] call_ret_addr_i,
   input  logic              ret_i,
   input  logic              flush_i,
   output logic [ADDR_W-1:0] pred_addr_o,
   output logic              pred_valid_o
);

   localparam int unsigned PTR_W = idx_width(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rtn_pred_stack: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("rtn_pred_stack: ADDR_W must be at least 1");
   end

   logic [PTR_W-1:0]  top_idx, wr_idx;
   logic [CNT_W-1:0]  stk_cnt;
   logic              wr_en;
   logic [ADDR_W-1:0] top_data;

   rtn_pred_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_en_i (push_en_i),
      .call_i    (call_i),
      .ret_i     (ret_i),
      .flush_i   (flush_i),
      .top_idx_o (top_idx),
      .count_o   (stk_cnt),
      .wr_en_o   (wr_en),
      .wr_idx_o  (wr_idx)
   );

   rtn_pred_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (call_ret_addr_i),
      .rd_idx_i  (top_idx),
      .rd_data_o (top_data)
   );

   // Prediction straight from the current top, same cycle as the strobe
   assign pred_valid_o = ret_i & ~flush_i & (stk_cnt != '0);
   assign pred_addr_o  = pred_valid_o ? top_data : '0;

   // R7: no prediction from an empty stack
   p_empty_novalid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stk_cnt == '0) |-> !pred_valid_o);

   // R9: flush suppresses any prediction in its cycle
   p_flush_novalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |-> !pred_valid_o);

   // R11: address is quiet when invalid
   p_quiet_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pred_valid_o |-> (pred_addr_o == '0));

endmodule

// File: tb/rtn_pred_stack_bench.sv
`timescale 1ns/1ps
module rtn_pred_stack_bench;

   localparam int unsigned AW  = 8;
   localparam int unsigned D_A = 4;
   localparam int unsigned D_B = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b1, call = 1'b0, ret = 1'b0, fl = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [AW-1:0] pa_a, pa_b;
   logic          pv_a, pv_b;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;
   int unsigned qa[$];
   int unsigned qb[$];

   always #10 clk = ~clk;

   rtn_pred_stack #(.DEPTH(D_A), .ADDR_W(AW)) u_rtn_pred_stack (
      .clk_i(clk), .rst_ni(rst_n), .push_en_i(en), .call_i(call),
      .call_ret_addr_i(addr), .ret_i(ret), .flush_i(fl),
      .pred_addr_o(pa_a), .pred_valid_o(pv_a));

   rtn_pred_stack #(.DEPTH(D_B), .ADDR_W(AW)) u_rtn_pred_stack_d3 (
      .clk_i(clk), .rst_ni(rst_n), .push_en_i(en), .call_i(call),
      .call_ret_addr_i(addr), .ret_i(ret), .flush_i(fl),
      .pred_addr_o(pa_b), .pred_valid_o(pv_b));

   task automatic chk(input string tag, input int unsigned got, input int unsigned exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // One cycle: drive at negedge, check combinational prediction, advance models
   task automatic cyc(input logic c, input logic r, input logic e, input logic f,
                      input logic [AW-1:0] a, input string tag);
      logic ev_a, ev_b;
      int unsigned ea, eb;
      @(negedge clk);
      call = c; ret = r; en = e; fl = f; addr = a;
      #2;
      ev_a = r && !f && (qa.size() > 0);
      ev_b = r && !f && (qb.size() > 0);
      ea = ev_a ? qa[qa.size()-1] : 0;
      eb = ev_b ? qb[qb.size()-1] : 0;
      chk({tag, " valid d4"}, 32'(pv_a), 32'(ev_a));
      chk({tag, " addr d4"},  32'(pa_a), ea);
      chk({tag, " valid d3"}, 32'(pv_b), 32'(ev_b));
      chk({tag, " addr d3"},  32'(pa_b), eb);
      if (f) begin
         qa.delete();
         qb.delete();
      end else begin
         if (r && qa.size() > 0) void'(qa.pop_back());
         if (r && qb.size() > 0) void'(qb.pop_back());
         if (c && e) begin
            qa.push_back(32'(a));
            qb.push_back(32'(a));
            if (qa.size() > D_A) void'(qa.pop_front());
            if (qb.size() > D_B) void'(qb.pop_front());
         end
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R10: return during reset predicts nothing
      ret = 1'b1;
      #35;
      chk("R10 in reset valid d4", 32'(pv_a), 0);
      chk("R10 in reset valid d3", 32'(pv_b), 0);
      @(negedge clk);
      ret = 1'b0;
      rst_n = 1'b1;
      cyc(0, 1, 1, 0, 8'h00, "R10 after reset");

      // R1 R2: LIFO order
      cyc(1, 0, 1, 0, 8'h11, "R1 push");
      cyc(1, 0, 1, 0, 8'h22, "R1 push");
      cyc(1, 0, 1, 0, 8'h33, "R1 push");
      cyc(0, 1, 1, 0, 8'h00, "R2 pop");
      cyc(0, 1, 1, 0, 8'h00, "R2 pop");
      cyc(0, 1, 1, 0, 8'h00, "R2 pop");
      // R7 R11: empty pops, then one entry only
      cyc(0, 1, 1, 0, 8'h00, "R7 empty pop");
      cyc(0, 1, 1, 0, 8'h00, "R7 empty pop");
      cyc(1, 0, 1, 0, 8'h44, "R7 push one");
      cyc(0, 1, 1, 0, 8'h00, "R7 single pop");
      cyc(0, 1, 1, 0, 8'h00, "R11 quiet addr");

      // R3 R4: disabled pushes, returns still pop
      cyc(1, 0, 1, 0, 8'h51, "R3 setup");
      cyc(1, 0, 1, 0, 8'h52, "R3 setup");
      cyc(1, 0, 0, 0, 8'hEE, "R3 call ignored");
      cyc(1, 0, 0, 0, 8'hEF, "R3 call ignored");
      cyc(0, 1, 0, 0, 8'h00, "R3 top kept");
      cyc(0, 1, 0, 0, 8'h00, "R4 older entry");
      cyc(0, 1, 0, 0, 8'h00, "R4 drained");

      // R6: overflow drops oldest
      for (int k = 0; k < 6; k++) cyc(1, 0, 1, 0, 8'(8'h60 + k), "R6 fill");
      for (int k = 0; k < 5; k++) cyc(0, 1, 1, 0, 8'h00, "R6 drain");

      // R8: call and return together
      cyc(1, 0, 1, 0, 8'h71, "R8 setup");
      cyc(1, 0, 1, 0, 8'h72, "R8 setup");
      cyc(1, 1, 1, 0, 8'h73, "R8 swap");
      cyc(0, 1, 1, 0, 8'h00, "R8 new top");
      cyc(0, 1, 1, 0, 8'h00, "R8 depth kept");
      cyc(0, 1, 1, 0, 8'h00, "R8 empty");
      cyc(1, 1, 1, 0, 8'h74, "R8 swap on empty");
      cyc(0, 1, 1, 0, 8'h00, "R8 swap on empty result");

      // R5: flush empties
      cyc(1, 0, 1, 0, 8'h81, "R5 setup");
      cyc(1, 0, 1, 0, 8'h82, "R5 setup");
      cyc(0, 0, 1, 1, 8'h00, "R5 flush");
      cyc(0, 1, 1, 0, 8'h00, "R5 after flush");

      // R9: flush wins over push and pop
      cyc(1, 0, 1, 0, 8'h91, "R9 setup");
      cyc(1, 0, 1, 0, 8'h92, "R9 setup");
      cyc(1, 1, 1, 1, 8'h93, "R9 flush priority");
      cyc(0, 1, 1, 0, 8'h00, "R9 nothing kept");

      // R10: reset mid-run empties
      cyc(1, 0, 1, 0, 8'hA1, "R10 setup");
      @(negedge clk);
      call = 1'b0;
      rst_n = 1'b0;
      qa.delete();
      qb.delete();
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 1, 1, 0, 8'h00, "R10 reset clears");

      // R2 sweep: pseudo-random mix of all strobes
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0], lfsr[1], lfsr[2] | lfsr[3], (lfsr[7:4] == 4'h0),
             lfsr[15:8], "R2 sweep");
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule